// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of single-word transfers. A request carries a base address, a 16-bit mask that selects registers, and five control flags:

- direction (load or store)
- step-before or step-after indexing
- increasing or decreasing addresses
- base write-back
- a special flag that asks for a status-register restore or for user-bank access

After a start strobe, the block offers one transfer at a time. Each transfer carries a register index, a word address and a direction. It holds that transfer until the consumer accepts it with `xfer_ready_i`. When the list is used up, the block pulses `done_o`. In that cycle it presents the write-back value, the write-back enable and the two special-flag outputs.

Registers always go out lowest index first, to the lowest address. The indexing flags therefore only choose the window of memory that the list covers. They never change the order within that window.

The block also contains a small combinational decoder. It converts an addressing-mode name into the step-before and increasing flags. The name can be a plain increment or decrement form, or a full, empty, ascending or descending stack form. The result depends on whether the operation is a load or a store.

Top module: `blk_xfer_seq`

## Requirements
- R1: The mode decoder maps `amode_i` to (`dec_pre_o`, `dec_up_o`) as follows.
  - Plain forms (bit 2 = 0): bit 0 = 1 means step-before, and bit 1 = 1 means decreasing. So 0 = inc-after (0,1), 1 = inc-before (1,1), 2 = dec-after (0,0) and 3 = dec-before (1,0).
  - Stack forms (bit 2 = 1): bit 0 = 1 means an empty stack, and bit 1 = 1 means an ascending stack. So 4 = full-desc, 5 = empty-desc, 6 = full-asc and 7 = empty-asc.
  - For a store, pre = full and up = ascending. For a load, pre = empty and up = descending.
- R2: Transfers are issued in increasing register index, one per set mask bit. Each accepted transfer that is followed by another one advances the address by exactly 4.
- R3: Let B be the base with its low two bits cleared, and n the number of set mask bits. The first address is:
  - B+4 for increasing step-before;
  - B for increasing step-after;
  - B−4n for decreasing step-before;
  - B−4n+4 for decreasing step-after.
- R4: Bits [1:0] of `xfer_addr_o` are always zero while `xfer_valid_o` is high.
- R5: `xfer_load_o` equals the load flag captured at start, for every transfer of that request.
- R6: At `done_o`, `wb_value_o` equals the raw base plus 4n (increasing) or minus 4n (decreasing). `wb_en_o` is 1 only when write-back was requested and n > 0.
- R7: At `done_o`, `psr_restore_o` is 1 only when the special flag is set, the request is a load and mask bit 15 is set. `user_bank_o` is 1 when the special flag is set and the restore condition does not hold. The two are never both 1.
- R8: A request with an all-zero mask issues no transfer and pulses `done_o` in the cycle after start, with `wb_en_o` = 0 and `wb_value_o` equal to the base.
- R9: While `xfer_valid_o` is high and `xfer_ready_i` is low, the index, address and direction stay unchanged in the next cycle.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last transfer is accepted. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register-select mask |
| load_i | input | 1 | 1 = load, 0 = store |
| pre_i | input | 1 | 1 = step before access |
| up_i | input | 1 | 1 = increasing addresses |
| wb_i | input | 1 | Write-back requested |
| sflag_i | input | 1 | Status restore / user-bank request |
| xfer_ready_i | input | 1 | Consumer accepts the current transfer |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_load_o | output | 1 | Direction of the transfer |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base should be written back |
| wb_value_o | output | 32 | Written-back base value |
| psr_restore_o | output | 1 | Restore status along with the PC |
| user_bank_o | output | 1 | Use the user-mode register bank |
| amode_i | input | 3 | Addressing-mode name code for the decoder |
| amode_load_i | input | 1 | Decoder: the name is used for a load |
| dec_pre_o | output | 1 | Decoded step-before flag |
| dec_up_o | output | 1 | Decoded increasing flag |

## Verification
The hardest situations to reach are decreasing modes whose window wraps below address zero, and start strobes that arrive while a request is still draining under back-pressure. To reach them, the stimulus picks bases near both ends of the address space and drives `xfer_ready_i` low at random. It also keeps raising `start_i` with fresh, different fields during busy periods, so any request captured by mistake would show up as a changed transfer stream. Masks with only bit 0, only bit 15, all bits and no bits are applied in every one of the four modes before the random phase begins.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;

  // mode name code fields
  localparam int unsigned AM_BIT_A    = 0; // plain: before / stack: empty
  localparam int unsigned AM_BIT_B    = 1; // plain: decrement / stack: ascending
  localparam int unsigned AM_BIT_STK  = 2;
endpackage

// File: rtl/bx_mode_decode.sv
module bx_mode_decode
  import blk_xfer_pkg::*;
(
  input  logic [2:0] amode_i,
  input  logic       is_load_i,
  output logic       pre_o,
  output logic       up_o
);
  logic bit_a, bit_b, stack_form;

  always_comb begin
    bit_a      = amode_i[AM_BIT_A];
    bit_b      = amode_i[AM_BIT_B];
    stack_form = amode_i[AM_BIT_STK];
    if (!stack_form) begin
      pre_o = bit_a;
      up_o  = !bit_b;
    end else if (is_load_i) begin
      // load pops: empty stacks step first, descending stacks climb
      pre_o = bit_a;
      up_o  = !bit_b;
    end else begin
      // store pushes: full stacks step first, ascending stacks climb
      pre_o = !bit_a;
      up_o  = bit_b;
    end
  end
endmodule

// File: rtl/bx_popcount.sv
module bx_popcount #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count_o = count_o + CNT_W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/bx_lowest_pick.sv
module bx_lowest_pick #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             single_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
    single_o = ((vec_i & (vec_i - WIDTH'(1))) == '0);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NREGS      = 16,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W  = $clog2(NREGS),
  localparam int unsigned CNT_W  = $clog2(NREGS + 1),
  localparam int unsigned WSHIFT = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREGS-1:0]  mask_i,
  input  logic              load_i,
  input  logic              pre_i,
  input  logic              up_i,
  input  logic              wb_i,
  input  logic              sflag_i,
  input  logic              xfer_ready_i,
  output logic              xfer_valid_o,
  output logic [IDX_W-1:0]  xfer_reg_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_value_o,
  output logic              psr_restore_o,
  output logic              user_bank_o,
  input  logic [2:0]        amode_i,
  input  logic              amode_load_i,
  output logic              dec_pre_o,
  output logic              dec_up_o
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(WORD_BYTES - 1);

  sq_state_e         state_q, state_d;
  logic [NREGS-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_q, load_d;
  logic [ADDR_W-1:0] wbval_q, wbval_d;
  logic              wben_q, wben_d;
  logic              rpsr_q, rpsr_d;
  logic              ubank_q, ubank_d;

  logic [CNT_W-1:0]  start_cnt;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_last;
  logic [ADDR_W-1:0] span, base_al, first_addr;
  logic              take_start, accept;
  logic              restore_hit;

  bx_mode_decode u_decode (
    .amode_i   (amode_i),
    .is_load_i (amode_load_i),
    .pre_o     (dec_pre_o),
    .up_o      (dec_up_o)
  );

  bx_popcount #(.WIDTH(NREGS)) u_count (
    .vec_i   (mask_i),
    .count_o (start_cnt)
  );

  bx_lowest_pick #(.WIDTH(NREGS)) u_pick (
    .vec_i    (rem_q),
    .idx_o    (cur_idx),
    .single_o (cur_last)
  );

  // start-time address arithmetic
  always_comb begin
    span    = ADDR_W'(start_cnt) << WSHIFT;
    base_al = base_i & ~LOW_MASK;
    if (up_i) begin
      first_addr = pre_i ? (base_al + STEP) : base_al;
    end else begin
      first_addr = pre_i ? (base_al - span) : (base_al - span + STEP);
    end
    restore_hit = sflag_i && load_i && mask_i[NREGS-1];
  end

  assign take_start = (state_q == SQ_IDLE) && start_i;
  assign accept     = (state_q == SQ_XFER) && xfer_ready_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    load_d  = load_q;
    wbval_d = wbval_q;
    wben_d  = wben_q;
    rpsr_d  = rpsr_q;
    ubank_d = ubank_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (take_start) begin
          rem_d   = mask_i;
          addr_d  = first_addr;
          load_d  = load_i;
          wbval_d = up_i ? (base_i + span) : (base_i - span);
          wben_d  = wb_i && (mask_i != '0);
          rpsr_d  = restore_hit;
          ubank_d = sflag_i && !restore_hit;
          state_d = (mask_i == '0) ? SQ_DONE : SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (accept) begin
          rem_d[cur_idx] = 1'b0;
          addr_d         = addr_q + STEP;
          if (cur_last) state_d = SQ_DONE;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      wbval_q <= '0;
      wben_q  <= 1'b0;
      rpsr_q  <= 1'b0;
      ubank_q <= 1'b0;
    end else begin
      if (take_start || accept) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (take_start) begin
        load_q  <= load_d;
        wbval_q <= wbval_d;
        wben_q  <= wben_d;
        rpsr_q  <= rpsr_d;
        ubank_q <= ubank_d;
      end
    end
  end

  assign xfer_valid_o  = (state_q == SQ_XFER);
  assign xfer_reg_o    = cur_idx;
  assign xfer_addr_o   = addr_q;
  assign xfer_load_o   = load_q;
  assign busy_o        = (state_q != SQ_IDLE);
  assign done_o        = (state_q == SQ_DONE);
  assign wb_en_o       = wben_q;
  assign wb_value_o    = wbval_q;
  assign psr_restore_o = rpsr_q;
  assign user_bank_o   = ubank_q;
endmodule

// File: rtl/bx_seq_checker.sv
module bx_seq_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_valid_o,
  input logic              xfer_ready_i,
  input logic [IDX_W-1:0]  xfer_reg_o,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic              xfer_load_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              psr_restore_o,
  input logic              user_bank_o
);
  assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_reg_o)
      && $stable(xfer_addr_o) && $stable(xfer_load_o)));

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (xfer_addr_o[1:0] == 2'b00));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_valid_o && xfer_ready_i) && xfer_valid_o)
      |-> (xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(4)));

  assert_index_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_valid_o && xfer_ready_i) && xfer_valid_o)
      |-> (xfer_reg_o > $past(xfer_reg_o)));

  assert_dir_constant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_valid_o) && xfer_valid_o) |-> $stable(xfer_load_o));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && $past(busy_o) |-> $past(xfer_valid_o && xfer_ready_i));

  assert_valid_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (busy_o && !done_o));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(psr_restore_o && user_bank_o));
endmodule

bind blk_xfer_seq bx_seq_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_valid_o  (xfer_valid_o),
  .xfer_ready_i  (xfer_ready_i),
  .xfer_reg_o    (xfer_reg_o),
  .xfer_addr_o   (xfer_addr_o),
  .xfer_load_o   (xfer_load_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .psr_restore_o (psr_restore_o),
  .user_bank_o   (user_bank_o)
);

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] mask_i;
  logic        load_i, pre_i, up_i, wb_i, sflag_i;
  logic        xfer_ready_i;
  logic        xfer_valid_o;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o;
  logic        xfer_load_o, busy_o, done_o, wb_en_o;
  logic [31:0] wb_value_o;
  logic        psr_restore_o, user_bank_o;
  logic [2:0]  amode_i;
  logic        amode_load_i;
  logic        dec_pre_o, dec_up_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .load_i(load_i), .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i), .sflag_i(sflag_i),
    .xfer_ready_i(xfer_ready_i), .xfer_valid_o(xfer_valid_o), .xfer_reg_o(xfer_reg_o),
    .xfer_addr_o(xfer_addr_o), .xfer_load_o(xfer_load_o), .busy_o(busy_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o),
    .psr_restore_o(psr_restore_o), .user_bank_o(user_bank_o),
    .amode_i(amode_i), .amode_load_i(amode_load_i),
    .dec_pre_o(dec_pre_o), .dec_up_o(dec_up_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int           m_phase;        // 0 idle, 1 transferring, 2 done
  int           q_reg[$];
  logic [31:0]  q_addr[$];
  logic         m_load, m_wben, m_rpsr, m_ubank;
  logic [31:0]  m_wbval;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      q_reg.delete();
      q_addr.delete();
      m_load = 0; m_wben = 0; m_rpsr = 0; m_ubank = 0; m_wbval = 0;
    end else begin
      cycles++;
      case (m_phase)
        0: if (start_i) begin
          int n;
          logic [31:0] b, lo;
          n = 0;
          for (int i = 0; i < 16; i++) if (mask_i[i]) n++;
          b = {base_i[31:2], 2'b00};
          if (up_i) lo = pre_i ? b + 4 : b;
          else      lo = pre_i ? b - 32'(4*n) : b - 32'(4*n) + 4;
          q_reg.delete();
          q_addr.delete();
          for (int i = 0, k = 0; i < 16; i++) begin
            if (mask_i[i]) begin
              q_reg.push_back(i);
              q_addr.push_back(lo + 32'(4*k));
              k++;
            end
          end
          m_load  = load_i;
          m_wbval = up_i ? base_i + 32'(4*n) : base_i - 32'(4*n);
          m_wben  = wb_i && (n > 0);
          m_rpsr  = sflag_i && load_i && mask_i[15];
          m_ubank = sflag_i && !m_rpsr;
          m_phase = (n == 0) ? 2 : 1;
        end
        1: if (xfer_ready_i) begin
          void'(q_reg.pop_front());
          void'(q_addr.pop_front());
          if (q_reg.size() == 0) m_phase = 2;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(xfer_valid_o == (m_phase == 1), "R10", "xfer_valid", 32'(xfer_valid_o), 32'(m_phase == 1));
      chk(busy_o == (m_phase != 0), "R10", "busy", 32'(busy_o), 32'(m_phase != 0));
      chk(done_o == (m_phase == 2), "R10", "done", 32'(done_o), 32'(m_phase == 2));
      if (m_phase == 1 && xfer_valid_o) begin
        chk(32'(xfer_reg_o) == 32'(q_reg[0]), "R2", "reg index", 32'(xfer_reg_o), 32'(q_reg[0]));
        chk(xfer_addr_o == q_addr[0], "R3", "address", xfer_addr_o, q_addr[0]);
        chk(xfer_addr_o[1:0] == 2'b00, "R4", "address low bits", 32'(xfer_addr_o[1:0]), 32'd0);
        chk(xfer_load_o == m_load, "R5", "direction", 32'(xfer_load_o), 32'(m_load));
      end
      if (m_phase == 2 && done_o) begin
        chk(wb_value_o == m_wbval, "R6", "wb value", wb_value_o, m_wbval);
        chk(wb_en_o == m_wben, "R6_R8", "wb enable", 32'(wb_en_o), 32'(m_wben));
        chk(psr_restore_o == m_rpsr, "R7", "psr restore", 32'(psr_restore_o), 32'(m_rpsr));
        chk(user_bank_o == m_ubank, "R7", "user bank", 32'(user_bank_o), 32'(m_ubank));
      end
    end
  end

  // ---------------- stimulus ----------------
  int ready_pct = 70;

  task automatic drive_req(input logic [31:0] b, input logic [15:0] m, input bit l,
                           input bit p, input bit u, input bit w, input bit s);
    base_i = b; mask_i = m; load_i = l; pre_i = p; up_i = u; wb_i = w; sflag_i = s;
  endtask

  // one request: wait idle, pulse start, keep junk starts while busy (R10)
  task automatic run_req(input logic [31:0] b, input logic [15:0] m, input bit l,
                         input bit p, input bit u, input bit w, input bit s);
    while (busy_o) begin
      @(negedge clk);
      xfer_ready_i = ($urandom_range(99) < ready_pct);
    end
    drive_req(b, m, l, p, u, w, s);
    start_i = 1'b1;
    @(negedge clk);
    start_i = $urandom_range(1);
    drive_req($urandom, 16'($urandom), $urandom_range(1), $urandom_range(1),
              $urandom_range(1), $urandom_range(1), $urandom_range(1));
    xfer_ready_i = ($urandom_range(99) < ready_pct);
    while (busy_o) begin
      @(negedge clk);
      xfer_ready_i = ($urandom_range(99) < ready_pct);
      start_i = $urandom_range(1);
    end
    start_i = 1'b0;
  endtask

  function automatic bit [1:0] exp_decode(input bit [2:0] code, input bit ld);
    bit pre, up;
    if (!code[2]) begin
      pre = code[0]; up = !code[1];
    end else begin
      bit empty_s, asc;
      empty_s = code[0]; asc = code[1];
      if (ld) begin pre = empty_s;  up = !asc; end
      else    begin pre = !empty_s; up = asc;  end
    end
    return {pre, up};
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 1'b0; xfer_ready_i = 1'b0;
    drive_req(32'h0, 16'h0, 0, 0, 0, 0, 0);
    amode_i = 3'd0; amode_load_i = 1'b0;

    // decoder table (R1), purely combinational
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 2; l++) begin
        bit [1:0] e;
        amode_i = 3'(c); amode_load_i = l[0];
        #1;
        e = exp_decode(3'(c), l[0]);
        chk({dec_pre_o, dec_up_o} == e, "R1", "mode decode", 32'({dec_pre_o, dec_up_o}), 32'(e));
      end
    end

    repeat (3) @(negedge clk);
    // reset state
    chk(!xfer_valid_o && !busy_o && !done_o, "R10", "reset outputs",
        32'({xfer_valid_o, busy_o, done_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: stall with ready low, then release
    ready_pct = 0;
    drive_req(32'h0000_1000, 16'h0005, 1, 0, 1, 1, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(xfer_valid_o && xfer_addr_o == 32'h1000 && xfer_reg_o == 4'd0, "R9", "held transfer",
        xfer_addr_o, 32'h1000);
    xfer_ready_i = 1'b1;
    @(negedge clk);
    xfer_ready_i = 1'b1;
    @(negedge clk);
    xfer_ready_i = 1'b0;
    ready_pct = 70;
    while (busy_o) @(negedge clk);

    // directed corners in all four modes, both directions
    for (int md = 0; md < 4; md++) begin
      for (int l = 0; l < 2; l++) begin
        bit pp, uu;
        pp = md[0]; uu = md[1];
        run_req(32'h0000_2003, 16'h0001, l[0], pp, uu, 1, 0);
        run_req(32'h0000_2000, 16'h8000, l[0], pp, uu, 1, 1);
        run_req(32'h0000_0008, 16'hFFFF, l[0], pp, uu, 1, 1);   // wraps below zero going down
        run_req(32'hFFFF_FFF0, 16'hA5A5, l[0], pp, uu, 0, 1);   // wraps above top going up
        run_req(32'h0000_4000, 16'h0000, l[0], pp, uu, 1, 1);   // R8 empty list
      end
    end

    // random requests
    for (int t = 0; t < 400; t++) begin
      logic [15:0] m;
      m = 16'($urandom);
      if ($urandom_range(9) == 0) m = 16'h0;
      run_req($urandom, m, $urandom_range(1), $urandom_range(1), $urandom_range(1),
              $urandom_range(1), $urandom_range(1));
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule